// File: doc/BRIEF.md
# Serial EEPROM Bit Shifter

This block drives the pins of a three-wire serial EEPROM: chip select, serial clock and serial data toward the device. It paces every pin change with a fixed settle interval counted in system clocks. The default interval is 2500 cycles, which is 50 µs at 50 MHz. A host asks for one of two operations with a single-cycle request:

- a **standby** sequence, which deselects and then reselects the device;
- a **shift-out** of 1 to 16 bits taken from a 16-bit word, sent most significant first.

While an operation runs, `busy` is high. When the last settle interval ends, `done` pulses for one cycle. Command framing (opcodes, addresses) and reading data back from the device are left to whatever sits above this block. The shift-out never touches chip select, so the host runs a standby sequence first to select the device and then issues one or more shifts.

Top module: `serial_prom_shifter`

## Requirements
- R1: After reset `prom_cs`, `prom_sck`, `prom_di`, `busy` and `done` are all low.
- R2: A shift-out of length L sends bits L-1 down to 0 of `shift_word`, most significant first. Each bit takes three steps: `prom_di` takes the bit value, then `prom_sck` goes high, then `prom_sck` goes low.
- R3: Each step holds its pin levels for exactly `SETTLE_CYC` clock cycles before the next step starts. The first step's levels appear on the cycle after the request is accepted.
- R4: A standby sequence takes four steps in this order: `{prom_cs,prom_sck}` = 00, 01, 11, 10. Chip select is active high. `prom_di` is left unchanged.
- R5: When a shift-out ends, `prom_di` is driven low. `prom_cs` keeps the level it had before the shift.
- R6: A shift request with a length of 0 or greater than 16 is rejected. `done` pulses on the next cycle, `busy` stays low and no pin moves.
- R7: Requests that arrive while `busy` is high are ignored. The running operation continues unchanged.
- R8: `done` is high for exactly one cycle. On an accepted operation it rises on the same cycle that `busy` falls, after 3·L·`SETTLE_CYC` cycles for a shift or 4·`SETTLE_CYC` cycles for a standby.
- R9: When both requests arrive together while idle, the standby sequence is performed.
- R10: While idle, the pins hold their levels whatever `shift_word` and `shift_len` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_standby | input | 1 | Request a standby sequence |
| start_shift | input | 1 | Request a shift-out |
| shift_word | input | 16 | Data word for a shift-out |
| shift_len | input | 5 | Number of bits to shift (1..16) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse at the end of an operation |
| prom_cs | output | 1 | Chip select to the EEPROM, active high |
| prom_sck | output | 1 | Serial clock to the EEPROM |
| prom_di | output | 1 | Serial data to the EEPROM |

## Verification
The bench targets the following corner cases and the failure each would show:

- **Length limits.** Lengths of 1 and 16 would expose an off-by-one in the starting bit position; such a design would send a shifted or truncated pattern. Lengths of 0 and 17 check the reject path; a wrong design would either clock the device or raise `busy`.
- **Standby and chip select.** The standby step order is checked cycle by cycle, so swapping the chip-select and clock steps shows up at once. A following shift must leave chip select asserted; a design that dropped it would leave the device deselected.
- **Requests while busy and simultaneous requests.** A request arriving mid-shift must not restart or redirect the operation. Simultaneous requests must give standby.
- **Cycle-exact checking.** Every cycle is compared against the expected pin levels, so a settle interval one cycle short or long is caught.

// File: rtl/sps_pkg.sv
package sps_pkg;

  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_STBY  = 2'd1,
    M_SHIFT = 2'd2
  } mode_e;

  typedef struct packed {
    logic cs;
    logic sck;
  } sb_pins_t;

  // Pin levels of each standby step, in the order they must be applied.
  function automatic sb_pins_t standby_pins(input logic [1:0] step);
    sb_pins_t p;
    case (step)
      2'd0:    p = '{cs: 1'b0, sck: 1'b0};
      2'd1:    p = '{cs: 1'b0, sck: 1'b1};
      2'd2:    p = '{cs: 1'b1, sck: 1'b1};
      default: p = '{cs: 1'b1, sck: 1'b0};
    endcase
    return p;
  endfunction

  // A shift length is legal when it lies in 1..max_bits.
  function automatic logic len_valid(input int unsigned len, input int unsigned max_bits);
    return (len != 0) && (len <= max_bits);
  endfunction

endpackage

// File: rtl/sps_settle_timer.sv
module sps_settle_timer #(
  parameter int unsigned SETTLE_CYC = 2500,
  localparam int unsigned CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expire
);

  logic [CW-1:0] cnt_q;

  assign expire = run && !restart && (cnt_q == CW'(SETTLE_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= expire ? '0 : cnt_q + CW'(1);
    end
  end

endmodule

// File: rtl/sps_bit_cursor.sv
module sps_bit_cursor #(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_idx,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             at_lsb
);

  logic [IDX_W-1:0] idx_q;

  assign idx    = idx_q;
  assign at_lsb = (idx_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (load) begin
      idx_q <= load_idx;
    end else if (step && !at_lsb) begin
      idx_q <= idx_q - IDX_W'(1);
    end
  end

endmodule

// File: rtl/serial_prom_shifter.sv
module serial_prom_shifter
  import sps_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned SETTLE_CYC = 2500,
  localparam int unsigned LEN_W = $clog2(DATA_W + 1),
  localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_standby,
  input  logic              start_shift,
  input  logic [DATA_W-1:0] shift_word,
  input  logic [LEN_W-1:0]  shift_len,
  output logic              busy,
  output logic              done,
  output logic              prom_cs,
  output logic              prom_sck,
  output logic              prom_di
);

  mode_e             mode_q;
  logic [1:0]        phase_q;
  logic [DATA_W-1:0] word_q;
  logic              cs_q, sck_q, di_q, done_q;

  logic              idle, len_ok;
  logic              accept_sb, accept_sh, reject_sh;
  logic              step_expire, bit_advance;
  logic [IDX_W-1:0]  start_idx, cur_idx, next_idx;
  logic              cur_at_lsb;

  // Named internal events, visible to the bound checker.
  assign idle      = (mode_q == M_IDLE);
  assign len_ok    = len_valid(32'(shift_len), DATA_W);
  assign accept_sb = idle && start_standby;
  assign accept_sh = idle && !start_standby && start_shift && len_ok;
  assign reject_sh = idle && !start_standby && start_shift && !len_ok;
  assign start_idx = IDX_W'(shift_len - LEN_W'(1));
  assign next_idx  = cur_idx - IDX_W'(1);
  assign bit_advance = (mode_q == M_SHIFT) && step_expire && (phase_q == 2'd2);

  sps_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept_sb || accept_sh),
    .run     (!idle),
    .expire  (step_expire)
  );

  sps_bit_cursor #(.IDX_W(IDX_W)) cursor_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept_sh),
    .load_idx (start_idx),
    .step     (bit_advance),
    .idx      (cur_idx),
    .at_lsb   (cur_at_lsb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_IDLE;
      phase_q <= 2'd0;
      word_q  <= '0;
      cs_q    <= 1'b0;
      sck_q   <= 1'b0;
      di_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (mode_q)
        M_IDLE: begin
          if (accept_sb) begin
            mode_q         <= M_STBY;
            phase_q        <= 2'd0;
            {cs_q, sck_q}  <= standby_pins(2'd0);
          end else if (accept_sh) begin
            mode_q  <= M_SHIFT;
            phase_q <= 2'd0;
            word_q  <= shift_word;
            di_q    <= shift_word[start_idx];
          end else if (reject_sh) begin
            done_q <= 1'b1;
          end
        end
        M_STBY: begin
          if (step_expire) begin
            if (phase_q == 2'd3) begin
              mode_q <= M_IDLE;
              done_q <= 1'b1;
            end else begin
              phase_q       <= phase_q + 2'd1;
              {cs_q, sck_q} <= standby_pins(phase_q + 2'd1);
            end
          end
        end
        M_SHIFT: begin
          if (step_expire) begin
            case (phase_q)
              2'd0: begin
                sck_q   <= 1'b1;
                phase_q <= 2'd1;
              end
              2'd1: begin
                sck_q   <= 1'b0;
                phase_q <= 2'd2;
              end
              default: begin
                phase_q <= 2'd0;
                if (cur_at_lsb) begin
                  mode_q <= M_IDLE;
                  di_q   <= 1'b0;
                  done_q <= 1'b1;
                end else begin
                  di_q <= word_q[next_idx];
                end
              end
            endcase
          end
        end
        default: mode_q <= M_IDLE;
      endcase
    end
  end

  assign busy     = !idle;
  assign done     = done_q;
  assign prom_cs  = cs_q;
  assign prom_sck = sck_q;
  assign prom_di  = di_q;

endmodule

// File: rtl/sps_checker.sv
module sps_checker #(
  parameter int unsigned SETTLE_CYC = 2500
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic cs,
  input logic sck,
  input logic di,
  input logic step_adv
);

  logic [2:0]  pins_d;
  logic        pin_move;
  logic [31:0] gap;

  assign pin_move = ({cs, sck, di} != pins_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_d <= 3'b000;
      gap    <= '0;
    end else begin
      pins_d <= {cs, sck, di};
      if (pin_move)           gap <= '0;
      else if (gap != '1)     gap <= gap + 32'd1;
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_fall_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_di_steady_at_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(di));

  assert_single_pin_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cs, sck, di} ^ pins_d) <= 1);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> !pin_move);

  assert_settle_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_move && $past(busy)) |-> (gap >= SETTLE_CYC - 1));

  assert_move_on_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_move && $past(busy)) |-> $past(step_adv));

endmodule

bind serial_prom_shifter sps_checker #(.SETTLE_CYC(SETTLE_CYC)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .cs       (prom_cs),
  .sck      (prom_sck),
  .di       (prom_di),
  .step_adv (step_expire)
);

// File: tb/serial_prom_shifter_tb_top.sv
module serial_prom_shifter_tb_top;

  localparam int unsigned S = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_standby = 1'b0;
  logic        start_shift = 1'b0;
  logic [15:0] shift_word = '0;
  logic [4:0]  shift_len = '0;
  logic        busy, done, prom_cs, prom_sck, prom_di;

  int total = 0;
  int bad = 0;
  logic cs_cur = 1'b0;
  logic di_cur = 1'b0;

  always #10 clk = ~clk;

  serial_prom_shifter #(.DATA_W(16), .SETTLE_CYC(S)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_standby(start_standby), .start_shift(start_shift),
    .shift_word(shift_word), .shift_len(shift_len), .busy(busy), .done(done),
    .prom_cs(prom_cs), .prom_sck(prom_sck), .prom_di(prom_di)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // kind: 0 shift, 1 standby, 2 reject. Returns {busy,done,cs,sck,di}.
  function automatic logic [4:0] model(input int kind, input int k, input logic [15:0] d,
                                       input int len, input logic cs0, input logic di0);
    int n, t, j, b, ph;
    logic [4:0] r;
    n = (kind == 0) ? 3 * len : (kind == 1) ? 4 : 0;
    t = n * S;
    if (k <= t) begin
      j = (k - 1) / S;
      if (kind == 0) begin
        b = j / 3; ph = j % 3;
        r = {1'b1, 1'b0, cs0, (ph == 1), d[len - 1 - b]};
      end else begin
        case (j)
          0: r = {2'b10, 2'b00, di0};
          1: r = {2'b10, 2'b01, di0};
          2: r = {2'b10, 2'b11, di0};
          default: r = {2'b10, 2'b10, di0};
        endcase
      end
    end else begin
      if (kind == 0)      r = {2'b00, cs0, 2'b00};
      else if (kind == 1) r = {2'b00, 2'b10, di0};
      else                r = {2'b00, cs0, 1'b0, di0};
      if (k == t + 1) r[3] = 1'b1;
    end
    return r;
  endfunction

  // Drives one request, compares every cycle with the model. poke: extra requests mid-run.
  task automatic run_op(input int kind, input logic [15:0] d, input int len,
                        input logic both, input logic poke, input string tag);
    int n, kmax;
    logic [4:0] e, a;
    logic cs0, di0;
    cs0 = cs_cur; di0 = di_cur;
    n = (kind == 0) ? 3 * len : (kind == 1) ? 4 : 0;
    kmax = n * S + 2;
    @(negedge clk);
    shift_word    = d;
    shift_len     = 5'(len);
    start_standby = (kind == 1);
    start_shift   = (kind != 1) || both;
    for (int k = 1; k <= kmax; k++) begin
      @(negedge clk);
      a = {busy, done, prom_cs, prom_sck, prom_di};
      e = model(kind, k, d, len, cs0, di0);
      chk(a[4:3] == e[4:3], "R8", int'(a[4:3]), int'(e[4:3]));
      chk(a[2:0] == e[2:0], tag, int'(a[2:0]), int'(e[2:0]));
      if (k == 1) begin
        start_standby = 1'b0; start_shift = 1'b0;
        shift_word = ~d;
      end
      if (poke && k == S + 2) begin
        start_standby = 1'b1; start_shift = 1'b1; shift_len = 5'd2;
      end
      if (poke && k == S + 3) begin
        start_standby = 1'b0; start_shift = 1'b0;
      end
    end
    cs_cur = prom_cs; di_cur = prom_di;
  endtask

  task automatic t_reset;
    chk({prom_cs, prom_sck, prom_di, busy, done} == 5'b0, "R1",
        int'({prom_cs, prom_sck, prom_di, busy, done}), 0);
  endtask

  task automatic t_idle_quiet;
    logic [2:0] p0;
    p0 = {prom_cs, prom_sck, prom_di};
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      shift_word = 16'(i * 16'h1357);
      shift_len  = 5'(i);
      chk({prom_cs, prom_sck, prom_di} == p0 && !busy, "R10",
          int'({prom_cs, prom_sck, prom_di}), int'(p0));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_op(0, 16'hA5C3, 16, 1'b0, 1'b0, "R2 R3 R5");
    run_op(0, 16'h0001, 1, 1'b0, 1'b0, "R2 R5");
    run_op(1, 16'h0000, 0, 1'b0, 1'b0, "R4 R3");
    run_op(0, 16'h000B, 5, 1'b0, 1'b1, "R7 R5");
    run_op(0, 16'h0000, 3, 1'b0, 1'b0, "R2");
    run_op(2, 16'hFFFF, 0, 1'b0, 1'b0, "R6");
    run_op(2, 16'hFFFF, 17, 1'b0, 1'b0, "R6");
    run_op(1, 16'h8000, 16, 1'b1, 1'b0, "R9");
    run_op(0, 16'h8000, 16, 1'b0, 1'b1, "R7");
    t_idle_quiet();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule